// File: doc/BRIEF.md
# PCI Configuration Cycle Request Decoder

This block sits on the host side of a host-to-PCI bridge. It turns a host access to a configuration data window into a single configuration request for a PCI master engine. Two local registers feed the decision. The first is the configuration address register, which names the target bus, device, function and register. The second is the bus-range register, which holds the number of the bus directly behind the bridge and the highest bus number reachable through it.

When the host touches the data window, the block compares the target bus against the bus range.

- If the target is the local bus, the block issues a type 0 request. Its address phase carries a one-hot IDSEL line.
- If the target lies beyond the local bus, up to the highest reachable bus, the block issues a type 1 request. The routing fields pass through unchanged.
- Any other target bus is refused at once with a host error. Nothing is sent to the engine.

Only one request can be in flight. The host is held off until the engine reports completion. The block then returns the read data, or all ones if the engine reports a master abort.

Top module: `cfgCycleDecoder`

## Requirements
- R1: The register select on `hostSel` decodes as follows:
  - Select 0 is the configuration address register.
  - Select 1 is the bus-range register.
  - Select 2 is the data window.
  - Select 3 reads zero, and writes to it are ignored.
  
  A read of select 0 or 1 returns the stored 32-bit value on `hostRdata`, with `hostRespValid` high in the cycle after acceptance.
- R2: The configuration address register has these fields: register number in bits [7:2], target bus in bits [15:8], device in bits [20:16] and function in bits [23:21]. Other bits are stored but do not affect the request. When the target bus equals the local bus number (bits [15:8] of the bus-range register), a data-window access issues a request with `reqType1`=0. Its address is {IDSEL[15:0], 5'b0, function, register, 2'b00}.
- R3: In a type 0 address, device n with n < NUM_IDSEL sets only address bit 16+n. A device number at or above NUM_IDSEL sets none of bits [31:16].
- R4: When the target bus is above the local bus number and at or below the maximum subordinate bus number (bits [31:24] of the bus-range register), the request has `reqType1`=1. Its address is {8'h00, bus, device, function, register, 2'b01}.
- R5: Any other target bus gives a response with `hostErr`=1 in the cycle after acceptance, and `reqValid` is never raised. For a write, the data is discarded.
- R6: A data-window read responds only after `cplValid`, one cycle later. When the engine does not report an abort, it returns `cplData`.
- R7: A data-window read that completes with `cplAbort`=1 returns 32'hFFFFFFFF.
- R8: A data-window write issues a request with `reqWrite`=1 and `reqData` equal to the host write data. It responds with `hostErr`=0 after completion.
- R9: `hostReady` is low from the acceptance of a data-window access until its response has been given, so only one request is outstanding.
- R10: While `reqValid` is high and `reqReady` is low, `reqValid`, `reqAddr`, `reqData`, `reqWrite` and `reqType1` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostValid | input | 1 | Host access request |
| hostReady | output | 1 | Block can accept a host access |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostSel | input | 2 | Register select |
| hostWdata | input | 32 | Host write data |
| hostRespValid | output | 1 | One-cycle response strobe |
| hostRdata | output | 32 | Read data, valid with the response |
| hostErr | output | 1 | Error flag, valid with the response |
| reqValid | output | 1 | Configuration request to engine |
| reqReady | input | 1 | Engine accepts the request |
| reqWrite | output | 1 | Request is a configuration write |
| reqType1 | output | 1 | Request is type 1 |
| reqAddr | output | 32 | Address phase value |
| reqData | output | 32 | Write data for the request |
| cplValid | input | 1 | Engine completion strobe |
| cplData | input | 32 | Read data from engine |
| cplAbort | input | 1 | Engine saw a master abort |

## Verification
The hardest state to reach is the gap between acceptance and completion. It needs an engine that both delays taking the request and delays completing it. The bench plays that engine itself. It holds `reqReady` low for a random number of cycles, then lets a random latency pass before pulsing `cplValid`, with aborts mixed in. During that gap it checks that the descriptor stays frozen and that the host stays blocked. Bus ranges are drawn so that the maximum subordinate number is sometimes below the local number, and target buses land on the local bus, inside the range, just past the maximum, and anywhere else.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;
  localparam int WORD_W   = 32;
  localparam int SEL_W    = 2;
  localparam int BUS_W    = 8;
  localparam int DEV_W    = 5;
  localparam int FUNC_W   = 3;
  localparam int REGN_W   = 6;
  localparam int IDSEL_LINES = 16;

  localparam logic [SEL_W-1:0] SEL_ADDR  = 2'd0;
  localparam logic [SEL_W-1:0] SEL_RANGE = 2'd1;
  localparam logic [SEL_W-1:0] SEL_DATA  = 2'd2;

  typedef enum logic [1:0] {KIND_T0, KIND_T1, KIND_BAD} accKind_t;

  typedef struct packed {
    logic wrAddr;
    logic wrRange;
    logic latchReq;
    logic loadReg;
    logic loadCpl;
    logic clearResp;
  } dpStrobe_t;
endpackage

// File: rtl/cfgDatapath.sv
module cfgDatapath
  import cfgdec_pkg::*;
#(
  parameter int NUM_IDSEL = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [SEL_W-1:0]  hostSel,
  input  logic              hostWrite,
  input  logic [WORD_W-1:0] hostWdata,
  input  logic [WORD_W-1:0] cplData,
  input  logic              cplAbort,
  output accKind_t          kind,
  output logic [WORD_W-1:0] reqAddr,
  output logic [WORD_W-1:0] reqData,
  output logic              reqWrite,
  output logic              reqType1,
  output logic [WORD_W-1:0] respData
);
  logic [WORD_W-1:0] cfgAddrQ, rangeQ;
  logic [BUS_W-1:0]  busNum, localBus, maxSubBus;
  logic [DEV_W-1:0]  devNum;
  logic [FUNC_W-1:0] funcNum;
  logic [REGN_W-1:0] regNum;
  logic [IDSEL_LINES-1:0] idselVec;
  logic [WORD_W-1:0] phase;

  // R2 field positions
  assign regNum    = cfgAddrQ[7:2];
  assign busNum    = cfgAddrQ[15:8];
  assign devNum    = cfgAddrQ[20:16];
  assign funcNum   = cfgAddrQ[23:21];
  assign localBus  = rangeQ[15:8];
  assign maxSubBus = rangeQ[31:24];

  // R1 register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgAddrQ <= '0;
      rangeQ   <= '0;
    end else begin
      if (strobe.wrAddr)  cfgAddrQ <= hostWdata;
      if (strobe.wrRange) rangeQ   <= hostWdata;
    end
  end

  // R2/R4/R5 range compare
  always_comb begin
    if (busNum == localBus)                              kind = KIND_T0;
    else if (busNum > localBus && busNum <= maxSubBus)   kind = KIND_T1;
    else                                                 kind = KIND_BAD;
  end

  // R3 IDSEL decode, lines past NUM_IDSEL stay low
  for (genvar g = 0; g < IDSEL_LINES; g++) begin : gIdsel
    if (g < NUM_IDSEL) begin : gOn
      assign idselVec[g] = (devNum == DEV_W'(g));
    end else begin : gOff
      assign idselVec[g] = 1'b0;
    end
  end

  always_comb begin
    if (kind == KIND_T1)
      phase = {8'h00, busNum, devNum, funcNum, regNum, 2'b01};
    else
      phase = {idselVec, 5'b0, funcNum, regNum, 2'b00};
  end

  // request descriptor, frozen until next accept (R10)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqAddr  <= '0;
      reqData  <= '0;
      reqWrite <= 1'b0;
      reqType1 <= 1'b0;
    end else if (strobe.latchReq) begin
      reqAddr  <= phase;
      reqData  <= hostWdata;
      reqWrite <= hostWrite;
      reqType1 <= (kind == KIND_T1);
    end
  end

  // response mux (R1, R6, R7)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respData <= '0;
    end else if (strobe.loadReg) begin
      case (hostSel)
        SEL_ADDR:  respData <= cfgAddrQ;
        SEL_RANGE: respData <= rangeQ;
        default:   respData <= '0;
      endcase
    end else if (strobe.loadCpl) begin
      if (reqWrite)      respData <= '0;
      else if (cplAbort) respData <= '1;
      else               respData <= cplData;
    end else if (strobe.clearResp) begin
      respData <= '0;
    end
  end
endmodule

// File: rtl/cfgControl.sv
module cfgControl
  import cfgdec_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostValid,
  input  logic             hostWrite,
  input  logic [SEL_W-1:0] hostSel,
  input  accKind_t         kind,
  input  logic             reqReady,
  input  logic             cplValid,
  output logic             hostReady,
  output logic             hostRespValid,
  output logic             hostErr,
  output logic             reqValid,
  output dpStrobe_t        strobe
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_RESP} state_t;
  state_t state, stateNext;
  logic errQ;
  logic accept, isData;

  assign accept = hostValid && (state == S_IDLE);
  assign isData = (hostSel == SEL_DATA);

  always_comb begin
    strobe    = '0;
    stateNext = state;
    case (state)
      S_IDLE: if (hostValid) begin
        if (isData) begin
          if (kind == KIND_BAD) begin
            strobe.clearResp = 1'b1;
            stateNext        = S_RESP;
          end else begin
            strobe.latchReq = 1'b1;
            stateNext       = S_ISSUE;
          end
        end else begin
          if (hostWrite) begin
            strobe.wrAddr    = (hostSel == SEL_ADDR);
            strobe.wrRange   = (hostSel == SEL_RANGE);
            strobe.clearResp = 1'b1;
          end else begin
            strobe.loadReg = 1'b1;
          end
          stateNext = S_RESP;
        end
      end
      S_ISSUE: if (reqReady) stateNext = S_WAIT;
      S_WAIT: if (cplValid) begin
        strobe.loadCpl = 1'b1;
        stateNext      = S_RESP;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      errQ  <= 1'b0;
    end else begin
      state <= stateNext;
      if (accept) errQ <= isData && (kind == KIND_BAD);
    end
  end

  assign hostReady     = (state == S_IDLE);
  assign reqValid      = (state == S_ISSUE);
  assign hostRespValid = (state == S_RESP);
  assign hostErr       = hostRespValid && errQ;

  a_r5_refused_locally: assert property (@(posedge clk) disable iff (!rstN)
    hostValid && hostReady && isData && kind == KIND_BAD |=> hostRespValid && hostErr && !reqValid);
  a_r9_legal_goes_out: assert property (@(posedge clk) disable iff (!rstN)
    hostValid && hostReady && isData && kind != KIND_BAD |=> reqValid && !hostReady);
  a_r10_valid_held: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqReady |=> reqValid);
  a_r6_resp_single: assert property (@(posedge clk) disable iff (!rstN)
    hostRespValid |=> hostReady && !hostRespValid);
endmodule

// File: rtl/cfgCycleDecoder.sv
module cfgCycleDecoder
  import cfgdec_pkg::*;
#(
  parameter int NUM_IDSEL = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostValid,
  output logic        hostReady,
  input  logic        hostWrite,
  input  logic [1:0]  hostSel,
  input  logic [31:0] hostWdata,
  output logic        hostRespValid,
  output logic [31:0] hostRdata,
  output logic        hostErr,
  output logic        reqValid,
  input  logic        reqReady,
  output logic        reqWrite,
  output logic        reqType1,
  output logic [31:0] reqAddr,
  output logic [31:0] reqData,
  input  logic        cplValid,
  input  logic [31:0] cplData,
  input  logic        cplAbort
);
  dpStrobe_t strobe;
  accKind_t  kind;

  cfgControl uCtrl (
    .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostWrite(hostWrite),
    .hostSel(hostSel), .kind(kind), .reqReady(reqReady), .cplValid(cplValid),
    .hostReady(hostReady), .hostRespValid(hostRespValid), .hostErr(hostErr),
    .reqValid(reqValid), .strobe(strobe)
  );

  cfgDatapath #(.NUM_IDSEL(NUM_IDSEL)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hostSel(hostSel),
    .hostWrite(hostWrite), .hostWdata(hostWdata), .cplData(cplData),
    .cplAbort(cplAbort), .kind(kind), .reqAddr(reqAddr), .reqData(reqData),
    .reqWrite(reqWrite), .reqType1(reqType1), .respData(hostRdata)
  );

  a_r3_idsel_onehot: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqType1 |-> $onehot0(reqAddr[31:16]) && reqAddr[15:11] == 5'b0);
  a_r2_r4_low_bits: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> reqAddr[1:0] == {1'b0, reqType1});
  a_r10_desc_stable: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqReady |=> $stable(reqAddr) && $stable(reqData) && $stable(reqWrite) && $stable(reqType1));
endmodule

// File: tb/sim_cfgCycleDecoder.sv
module sim_cfgCycleDecoder;
  localparam int NID = 16;
  logic clk = 0, rstN = 0;
  logic hostValid = 0, hostWrite = 0, reqReady = 0, cplValid = 0, cplAbort = 0;
  logic [1:0] hostSel = 0;
  logic [31:0] hostWdata = 0, cplData = 0;
  logic hostReady, hostRespValid, hostErr, reqValid, reqWrite, reqType1;
  logic [31:0] hostRdata, reqAddr, reqData;

  int checks = 0, errors = 0;
  logic [31:0] lastRd, seenAddr, seenData;
  logic lastErr, sawReq, seenWr, seenT1;

  always #2.5 clk = ~clk;

  cfgCycleDecoder #(.NUM_IDSEL(NID)) u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int expKind(input logic [31:0] a, input logic [31:0] r);
    if (a[15:8] == r[15:8]) return 0;
    if (a[15:8] > r[15:8] && a[15:8] <= r[31:24]) return 1;
    return 2;
  endfunction

  function automatic logic [15:0] expIdsel(input logic [4:0] dev);
    return (dev < NID) ? (16'h1 << dev) : 16'h0;
  endfunction

  function automatic logic [31:0] expPhase(input logic [31:0] a, input logic [31:0] r);
    if (expKind(a, r) == 1) return {8'h00, a[15:8], a[20:16], a[23:21], a[7:2], 2'b01};
    return {expIdsel(a[20:16]), 5'b0, a[23:21], a[7:2], 2'b00};
  endfunction

  task automatic hostOp(input bit wr, input logic [1:0] sel, input logic [31:0] wd,
                        input bit ab, input logic [31:0] cd);
    int guard;
    int stall;
    int lat;
    sawReq = 0; lastRd = 0; lastErr = 0;
    @(negedge clk);
    hostValid = 1; hostWrite = wr; hostSel = sel; hostWdata = wd;
    chk(hostReady, "R9 ready when idle", 32'(hostReady), 1);
    @(negedge clk);
    hostValid = 0;
    guard = 0;
    while (!hostRespValid && guard < 80) begin
      if (reqValid && !sawReq) begin
        sawReq = 1; seenAddr = reqAddr; seenData = reqData; seenWr = reqWrite; seenT1 = reqType1;
        stall = $urandom % 3;
        for (int k = 0; k < stall; k++) begin
          @(negedge clk);
          chk(reqValid && reqAddr == seenAddr && reqData == seenData && reqWrite == seenWr && reqType1 == seenT1,
              "R10 descriptor held", reqAddr, seenAddr);
        end
        reqReady = 1;
        @(negedge clk);
        reqReady = 0;
        lat = 1 + $urandom % 3;
        for (int k = 0; k < lat; k++) begin
          chk(!hostReady && !hostRespValid, "R9 busy until completion", {hostReady, hostRespValid}, 0);
          @(negedge clk);
        end
        cplValid = 1; cplData = cd; cplAbort = ab;
        @(negedge clk);
        cplValid = 0; cplAbort = 0;
      end else begin
        @(negedge clk);
        guard++;
      end
    end
    chk(hostRespValid, "R6 response arrives", 32'(hostRespValid), 1);
    lastRd = hostRdata; lastErr = hostErr;
  endtask

  task automatic dataOp(input logic [31:0] a, input logic [31:0] r, input bit wr,
                        input logic [31:0] wd, input bit ab, input logic [31:0] cd);
    int k;
    hostOp(1, 2'd1, r, 0, 0);
    hostOp(1, 2'd0, a, 0, 0);
    hostOp(wr, 2'd2, wd, ab, cd);
    k = expKind(a, r);
    if (k == 2) begin
      chk(!sawReq, "R5 no request for bad bus", 32'(sawReq), 0);
      chk(lastErr, "R5 error flagged", 32'(lastErr), 1);
    end else begin
      chk(sawReq && !lastErr, "R2 legal access issued", {sawReq, lastErr}, 2);
      if (k == 0) begin
        chk(seenAddr == expPhase(a, r) && !seenT1, "R2 type 0 phase", seenAddr, expPhase(a, r));
        chk(seenAddr[31:16] == expIdsel(a[20:16]), "R3 idsel line", seenAddr, 32'(expIdsel(a[20:16])));
      end else begin
        chk(seenAddr == expPhase(a, r) && seenT1, "R4 type 1 phase", seenAddr, expPhase(a, r));
      end
      chk(seenWr == wr, "R8 write flag", 32'(seenWr), 32'(wr));
      if (wr) chk(seenData == wd, "R8 write data", seenData, wd);
      else if (ab) chk(lastRd == 32'hFFFF_FFFF, "R7 abort reads ones", lastRd, 32'hFFFF_FFFF);
      else chk(lastRd == cd, "R6 read data", lastRd, cd);
    end
  endtask

  initial begin
    #(5ns * 150000);
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] a, r, rv;
    logic [7:0] lb, ms, bus;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(hostReady && !reqValid && !hostRespValid, "R9 reset idle", {hostReady, reqValid, hostRespValid}, 4);
    rstN = 1;
    hostOp(0, 2'd0, 0, 0, 0);
    chk(lastRd == 0, "R1 reset address reg", lastRd, 0);
    hostOp(1, 2'd1, 32'hA5C3_1E07, 0, 0);
    hostOp(0, 2'd1, 0, 0, 0);
    chk(lastRd == 32'hA5C3_1E07, "R1 range readback", lastRd, 32'hA5C3_1E07);
    hostOp(1, 2'd3, 32'hFFFF_FFFF, 0, 0);
    hostOp(0, 2'd3, 0, 0, 0);
    chk(lastRd == 0, "R1 select 3 reads zero", lastRd, 0);
    hostOp(0, 2'd1, 0, 0, 0);
    chk(lastRd == 32'hA5C3_1E07, "R1 select 3 write ignored", lastRd, 32'hA5C3_1E07);
    // directed corners: range local 4, max 9
    r = {8'd9, 8'd0, 8'd4, 8'd0};
    dataOp({8'h0, 3'd2, 5'd0,  8'd4, 6'd3, 2'b0}, r, 0, 0, 0, 32'h1234_5678);
    dataOp({8'h0, 3'd1, 5'd15, 8'd4, 6'd9, 2'b0}, r, 1, 32'hCAFE_0001, 0, 0);
    dataOp({8'h0, 3'd1, 5'd16, 8'd4, 6'd9, 2'b0}, r, 0, 0, 0, 32'h0BAD_F00D);
    dataOp({8'h0, 3'd7, 5'd31, 8'd9, 6'd63, 2'b0}, r, 0, 0, 1, 32'h0);
    dataOp({8'h0, 3'd0, 5'd3,  8'd10, 6'd1, 2'b0}, r, 1, 32'hDEAD_0002, 0, 0);
    dataOp({8'h0, 3'd0, 5'd3,  8'd3, 6'd1, 2'b0}, r, 0, 0, 0, 0);
    for (int i = 0; i < 300; i++) begin
      lb = 8'($urandom);
      ms = ($urandom % 4 == 0) ? 8'(lb - 8'($urandom % 3)) : 8'(lb + 8'($urandom % 20));
      case ($urandom % 4)
        0: bus = lb;
        1: bus = 8'(lb + 1 + $urandom % 8);
        2: bus = 8'(ms + 1 + $urandom % 3);
        default: bus = 8'($urandom);
      endcase
      rv = $urandom;
      r = {ms, rv[23:16], lb, rv[7:0]};
      a = {rv[31:24], 3'($urandom), 5'($urandom), bus, 6'($urandom), rv[9:8]};
      dataOp(a, r, 1'($urandom), $urandom, ($urandom % 4 == 0), $urandom);
      if (i % 10 == 0) begin
        hostOp(0, 2'd0, 0, 0, 0);
        chk(lastRd == a, "R1 address readback", lastRd, a);
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule